// File: doc/BRIEF.md
# Cross-Clock Incrementing Token Loop

Two controllers, each in its own clock domain, keep a counter value moving between them. Side A owns register A and side B owns register B. After reset both registers hold zero and side A sends its value to side B over the forward channel. Side B adds one, stores the sum and returns it over the reverse channel. Side A adds one, stores that sum and sends it forward again. The exchange runs without end, so side B stores the odd values 1, 3, 5, … and side A stores the even values 2, 4, 6, …, all modulo 2^WIDTH.

Each channel has a request line from the sender, an acknowledge line from the receiver and a WIDTH-bit data bus. The `FOUR_PHASE` parameter picks one of two handshakes, and it is fixed when the block is built. In the level (four-phase) handshake, request high means the data is valid and acknowledge high means it has been taken, and both lines return low before the next transfer starts. In the transition (two-phase) handshake, every change of the request level offers a new datum and every change of the acknowledge level confirms it. Every handshake line that crosses a domain goes through a two-flop synchronizer on the receiving side, and every handshake line a side drives comes straight from a flip-flop. The data buses are not synchronized. The protocol keeps a bus stable for as long as the receiver may sample it.

Each side runs the same controller with these states:
- `ST_SEND` raises the request (four-phase) or toggles it (two-phase).
- `ST_WAIT_ACK` waits for the synchronized acknowledge: a high level in four-phase mode, a level change in two-phase mode.
- `ST_WAIT_REL` (four-phase only) waits for the acknowledge to return low.
- `ST_RECV` waits for an incoming request: a high level in four-phase mode, a level change in two-phase mode. On that request the side loads the incoming value plus one and raises or toggles its acknowledge.
- `ST_WAIT_DROP` (four-phase only) waits for the request to fall, then lowers the acknowledge.

Side A leaves reset in `ST_SEND` and side B in `ST_RECV`. In four-phase mode the cycle is `ST_SEND`→`ST_WAIT_ACK`→`ST_WAIT_REL`→`ST_RECV`→`ST_WAIT_DROP`→`ST_SEND`. In two-phase mode it is `ST_SEND`→`ST_WAIT_ACK`→`ST_RECV`→`ST_SEND`.

Top module: `xclk_incr_loop`

## Requirements
- R1: While its reset is asserted, each side holds its register at 0, its load pulse low and both handshake lines it drives low.
- R2: The first transfer after reset goes from A to B. Side B therefore loads 1 first. After that the loads alternate B, A, B, A, with values 1, 2, 3, 4, …
- R3: A receiving side loads the received value plus one. The loads on side B are 1, 3, 5, … and the loads on side A are 2, 4, 6, …, so successive loads on one side differ by exactly 2.
- R4: In four-phase mode a request rises only while the matching acknowledge is low. It stays high until the acknowledge has been seen high, and it falls only while the acknowledge is high.
- R5: In two-phase mode each datum takes exactly one change of the request level and one change of the acknowledge level. The count of request changes leads the count of acknowledge changes by 0 or 1, never more, and a request never changes in two consecutive cycles.
- R6: The load flag of a side is high for exactly one cycle of that side's clock for each value it accepts.
- R7: Values wrap modulo 2^WIDTH. With WIDTH = 8, side B loads 255 and side A then loads 0.
- R8: The sender's register, which drives its data bus, does not change while its transfer is outstanding. In four-phase mode that is while the request is high. In two-phase mode it is while the request level differs from the acknowledge level.
- R9: A change of the forward request does not reach the forward acknowledge before at least two rising edges of clock B have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock of side A |
| rst_a_n | input | 1 | Asynchronous active-low reset of side A |
| clk_b | input | 1 | Clock of side B |
| rst_b_n | input | 1 | Asynchronous active-low reset of side B |
| a_value | output | WIDTH | Register A, also the forward data bus |
| a_loaded | output | 1 | One clk_a pulse when side A loads a new value |
| b_value | output | WIDTH | Register B, also the reverse data bus |
| b_loaded | output | 1 | One clk_b pulse when side B loads a new value |
| ab_req | output | 1 | Forward request, registered in domain A |
| ab_ack | output | 1 | Forward acknowledge, registered in domain B |
| ba_req | output | 1 | Reverse request, registered in domain B |
| ba_ack | output | 1 | Reverse acknowledge, registered in domain A |

## Verification
The bench targets four failure modes:
- **Lost or doubled transition.** In two-phase mode, if a side missed a transition or saw the same one twice, the loop would stall or a value would be skipped, and the step-of-two check would fail.
- **Broken wrap.** If the increment were computed at the wrong width, the value after 255 would not be 0.
- **Bypassed synchronizer.** The bench measures acknowledge latency in clock B cycles. An acknowledge that answered too early would show up there.
- **Broken four-phase ordering.** If a request rose again before the acknowledge had returned to zero, the rise would be seen while the acknowledge was still high.

Both handshake modes are built side by side and share clocks with a 2:3 period ratio. The alternating order of the first ten loads is compared against a fixed table.

// File: rtl/xloop_pkg.sv
package xloop_pkg;

    typedef enum logic [2:0] {
        ST_SEND,
        ST_WAIT_ACK,
        ST_WAIT_REL,
        ST_RECV,
        ST_WAIT_DROP
    } node_state_t;

endpackage

// File: rtl/xloop_sync.sv
module xloop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[LAST-1:0], d};
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/xloop_node.sv
module xloop_node
    import xloop_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter bit FOUR_PHASE  = 1'b1,
    parameter bit SENDS_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in_s,
    input  logic             ack_in_s,
    input  logic [WIDTH-1:0] din,
    output logic             req_out,
    output logic             ack_out,
    output logic [WIDTH-1:0] value,
    output logic             loaded
);
    localparam node_state_t     ST_INIT = SENDS_FIRST ? ST_SEND : ST_RECV;
    localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);

    node_state_t state, state_nx;
    logic        ack_last;
    logic        req_last;
    logic        ack_event;
    logic        req_event;

    // A two-phase event stays pending until the state that consumes it runs.
    assign ack_event = FOUR_PHASE ? ack_in_s : (ack_in_s != ack_last);
    assign req_event = FOUR_PHASE ? req_in_s : (req_in_s != req_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_INIT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SEND:      state_nx = ST_WAIT_ACK;
            ST_WAIT_ACK:  if (ack_event) state_nx = FOUR_PHASE ? ST_WAIT_REL : ST_RECV;
            ST_WAIT_REL:  if (!ack_in_s) state_nx = ST_RECV;
            ST_RECV:      if (req_event) state_nx = FOUR_PHASE ? ST_WAIT_DROP : ST_SEND;
            ST_WAIT_DROP: if (!req_in_s) state_nx = ST_SEND;
            default:      state_nx = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_out  <= 1'b0;
            ack_out  <= 1'b0;
            value    <= '0;
            loaded   <= 1'b0;
            ack_last <= 1'b0;
            req_last <= 1'b0;
        end else begin
            loaded <= 1'b0;
            unique case (state)
                ST_SEND: begin
                    req_out <= FOUR_PHASE ? 1'b1 : ~req_out;
                end
                ST_WAIT_ACK: begin
                    if (ack_event) begin
                        ack_last <= ack_in_s;
                        if (FOUR_PHASE) begin
                            req_out <= 1'b0;
                        end
                    end
                end
                ST_RECV: begin
                    if (req_event) begin
                        req_last <= req_in_s;
                        value    <= din + ONE;
                        loaded   <= 1'b1;
                        ack_out  <= FOUR_PHASE ? 1'b1 : ~ack_out;
                    end
                end
                ST_WAIT_DROP: begin
                    if (!req_in_s) begin
                        ack_out <= 1'b0;
                    end
                end
                default: begin
                    loaded <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/xclk_incr_loop.sv
module xclk_incr_loop #(
    parameter int WIDTH      = 8,
    parameter bit FOUR_PHASE = 1'b1
) (
    input  logic             clk_a,
    input  logic             rst_a_n,
    input  logic             clk_b,
    input  logic             rst_b_n,
    output logic [WIDTH-1:0] a_value,
    output logic             a_loaded,
    output logic [WIDTH-1:0] b_value,
    output logic             b_loaded,
    output logic             ab_req,
    output logic             ab_ack,
    output logic             ba_req,
    output logic             ba_ack
);
    localparam int SYNC_STAGES = 2;

    logic a_ack_s;   // ab_ack seen in domain A
    logic a_req_s;   // ba_req seen in domain A
    logic b_req_s;   // ab_req seen in domain B
    logic b_ack_s;   // ba_ack seen in domain B

    xloop_sync #(.STAGES(SYNC_STAGES)) u_sync_a_ack (
        .clk(clk_a), .rst_n(rst_a_n), .d(ab_ack), .q(a_ack_s)
    );
    xloop_sync #(.STAGES(SYNC_STAGES)) u_sync_a_req (
        .clk(clk_a), .rst_n(rst_a_n), .d(ba_req), .q(a_req_s)
    );
    xloop_sync #(.STAGES(SYNC_STAGES)) u_sync_b_req (
        .clk(clk_b), .rst_n(rst_b_n), .d(ab_req), .q(b_req_s)
    );
    xloop_sync #(.STAGES(SYNC_STAGES)) u_sync_b_ack (
        .clk(clk_b), .rst_n(rst_b_n), .d(ba_ack), .q(b_ack_s)
    );

    xloop_node #(
        .WIDTH(WIDTH), .FOUR_PHASE(FOUR_PHASE), .SENDS_FIRST(1'b1)
    ) u_side_a (
        .clk      (clk_a),
        .rst_n    (rst_a_n),
        .req_in_s (a_req_s),
        .ack_in_s (a_ack_s),
        .din      (b_value),
        .req_out  (ab_req),
        .ack_out  (ba_ack),
        .value    (a_value),
        .loaded   (a_loaded)
    );

    xloop_node #(
        .WIDTH(WIDTH), .FOUR_PHASE(FOUR_PHASE), .SENDS_FIRST(1'b0)
    ) u_side_b (
        .clk      (clk_b),
        .rst_n    (rst_b_n),
        .req_in_s (b_req_s),
        .ack_in_s (b_ack_s),
        .din      (a_value),
        .req_out  (ba_req),
        .ack_out  (ab_ack),
        .value    (b_value),
        .loaded   (b_loaded)
    );
endmodule

// File: rtl/xloop_checker.sv
module xloop_checker #(
    parameter int WIDTH      = 8,
    parameter bit FOUR_PHASE = 1'b1
) (
    input logic             clk_a,
    input logic             rst_a_n,
    input logic             clk_b,
    input logic             rst_b_n,
    input logic [WIDTH-1:0] a_value,
    input logic [WIDTH-1:0] b_value,
    input logic             a_loaded,
    input logic             b_loaded,
    input logic             ab_req,
    input logic             a_ack_s
);
    p_b_step_r3: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        b_loaded |-> (b_value == WIDTH'(a_value + WIDTH'(1))));

    p_a_step_r3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_loaded |-> (a_value == WIDTH'(b_value + WIDTH'(1))));

    p_a_pulse_r6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_loaded |=> !a_loaded);

    p_b_pulse_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        b_loaded |=> !b_loaded);

    if (FOUR_PHASE) begin : g_four
        p_req_hold_r4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
            (ab_req && !a_ack_s) |=> ab_req);

        p_req_rise_r4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
            $rose(ab_req) |-> !a_ack_s);

        p_data_hold_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
            (ab_req && !a_ack_s) |=> $stable(a_value));
    end else begin : g_two
        p_one_toggle_r5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
            (ab_req != $past(ab_req)) |=> $stable(ab_req));

        p_data_hold_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
            (ab_req != a_ack_s) |=> $stable(a_value));
    end
endmodule

bind xclk_incr_loop xloop_checker #(
    .WIDTH(WIDTH), .FOUR_PHASE(FOUR_PHASE)
) u_xloop_checker (
    .clk_a    (clk_a),
    .rst_a_n  (rst_a_n),
    .clk_b    (clk_b),
    .rst_b_n  (rst_b_n),
    .a_value  (a_value),
    .b_value  (b_value),
    .a_loaded (a_loaded),
    .b_loaded (b_loaded),
    .ab_req   (ab_req),
    .a_ack_s  (a_ack_s)
);

// File: tb/test_xclk_incr_loop.sv
`timescale 1ns/1ps

module loop_mon #(
    parameter int    WIDTH = 8,
    parameter int    START = 1,
    parameter string NAME  = "side"
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loaded,
    input  logic [WIDTH-1:0] value,
    output int               checks,
    output int               fails,
    output int               loads,
    output logic             wrapped
);
    int               n_chk  = 0;
    int               n_fail = 0;
    int               n_ld   = 0;
    logic             wr     = 1'b0;
    logic             last   = 1'b0;
    logic [WIDTH-1:0] exp_v  = WIDTH'(START);

    assign checks  = n_chk;
    assign fails   = n_fail;
    assign loads   = n_ld;
    assign wrapped = wr;

    always @(negedge clk) begin
        if (rst_n) begin
            if (loaded) begin
                n_chk = n_chk + 2;
                if (value !== exp_v) begin
                    n_fail++;
                    $display("FAIL R3/R7 %s load %0d: got %0d expected %0d", NAME, n_ld, value, exp_v);
                end
                if (last) begin
                    n_fail++;
                    $display("FAIL R6 %s load flag high two cycles: got 1 expected 0", NAME);
                end
                if (value == '0) wr = 1'b1;
                exp_v = exp_v + WIDTH'(2);
                n_ld++;
            end
            last = loaded;
        end
    end
endmodule

module test_xclk_incr_loop;
    localparam int W = 8;

    // Entry: {side B?, value}; order of loads after reset (R2, R3)
    localparam logic [W:0] VEC [10] = '{
        {1'b1, 8'd1}, {1'b0, 8'd2}, {1'b1, 8'd3}, {1'b0, 8'd4}, {1'b1, 8'd5},
        {1'b0, 8'd6}, {1'b1, 8'd7}, {1'b0, 8'd8}, {1'b1, 8'd9}, {1'b0, 8'd10}
    };

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_a_n = 1'b0;
    logic rst_b_n = 1'b0;
    logic wd = 1'b0;

    always #2.667 clk_a = ~clk_a;   // two thirds of the clk_b period
    always #4     clk_b = ~clk_b;   // 125 MHz

    logic [W-1:0] fp_a_value, fp_b_value, tp_a_value, tp_b_value;
    logic fp_a_loaded, fp_b_loaded, fp_ab_req, fp_ab_ack, fp_ba_req, fp_ba_ack;
    logic tp_a_loaded, tp_b_loaded, tp_ab_req, tp_ab_ack, tp_ba_req, tp_ba_ack;

    xclk_incr_loop #(.WIDTH(W), .FOUR_PHASE(1'b1)) i_xclk_incr_loop (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
        .a_value(fp_a_value), .a_loaded(fp_a_loaded),
        .b_value(fp_b_value), .b_loaded(fp_b_loaded),
        .ab_req(fp_ab_req), .ab_ack(fp_ab_ack), .ba_req(fp_ba_req), .ba_ack(fp_ba_ack)
    );

    xclk_incr_loop #(.WIDTH(W), .FOUR_PHASE(1'b0)) i_xclk_incr_loop_2p (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
        .a_value(tp_a_value), .a_loaded(tp_a_loaded),
        .b_value(tp_b_value), .b_loaded(tp_b_loaded),
        .ab_req(tp_ab_req), .ab_ack(tp_ab_ack), .ba_req(tp_ba_req), .ba_ack(tp_ba_ack)
    );

    int m_chk [4];
    int m_fail[4];
    int m_ld  [4];
    logic m_wr[4];

    loop_mon #(.WIDTH(W), .START(2), .NAME("4ph A")) u_m0 (clk_a, rst_a_n, fp_a_loaded, fp_a_value, m_chk[0], m_fail[0], m_ld[0], m_wr[0]);
    loop_mon #(.WIDTH(W), .START(1), .NAME("4ph B")) u_m1 (clk_b, rst_b_n, fp_b_loaded, fp_b_value, m_chk[1], m_fail[1], m_ld[1], m_wr[1]);
    loop_mon #(.WIDTH(W), .START(2), .NAME("2ph A")) u_m2 (clk_a, rst_a_n, tp_a_loaded, tp_a_value, m_chk[2], m_fail[2], m_ld[2], m_wr[2]);
    loop_mon #(.WIDTH(W), .START(1), .NAME("2ph B")) u_m3 (clk_b, rst_b_n, tp_b_loaded, tp_b_value, m_chk[3], m_fail[3], m_ld[3], m_wr[3]);

    int n_chk = 0, n_fail = 0;      // main flow
    int pa_chk = 0, pa_fail = 0;    // domain A protocol monitor
    int pb_chk = 0, pb_fail = 0;    // domain B latency monitor

    // Handshake ordering (R4, R5) and data stability (R8), sampled in domain A
    logic f_req_q = 0, t_req_q = 0, t_ack_q = 0, f_out_q = 0, t_out_q = 0;
    logic [W-1:0] f_val_q = '0, t_val_q = '0;
    int t_rq_n = 0, t_ak_n = 0;
    always @(negedge clk_a) begin
        if (rst_a_n && rst_b_n) begin
            if (fp_ab_req && !f_req_q) begin
                pa_chk++;
                if (fp_ab_ack) begin pa_fail++; $display("FAIL R4 request rose with ack high: got ack 1 expected 0"); end
            end
            if (!fp_ab_req && f_req_q) begin
                pa_chk++;
                if (!fp_ab_ack) begin pa_fail++; $display("FAIL R4 request fell before ack: got ack 0 expected 1"); end
            end
            if (fp_ab_req && f_out_q) begin
                pa_chk++;
                if (fp_a_value != f_val_q) begin pa_fail++; $display("FAIL R8 4ph bus moved: got %0d expected %0d", fp_a_value, f_val_q); end
            end
            if (tp_ab_req != t_req_q) t_rq_n++;
            if (tp_ab_ack != t_ack_q) t_ak_n++;
            if ((tp_ab_req != t_req_q) || (tp_ab_ack != t_ack_q)) begin
                pa_chk++;
                if ((t_rq_n - t_ak_n) < 0 || (t_rq_n - t_ak_n) > 1) begin
                    pa_fail++;
                    $display("FAIL R5 toggle lead: got %0d expected 0 or 1", t_rq_n - t_ak_n);
                end
            end
            if ((tp_ab_req != tp_ab_ack) && t_out_q) begin
                pa_chk++;
                if (tp_a_value != t_val_q) begin pa_fail++; $display("FAIL R8 2ph bus moved: got %0d expected %0d", tp_a_value, t_val_q); end
            end
            f_out_q = fp_ab_req;
            t_out_q = (tp_ab_req != tp_ab_ack);
        end
        f_req_q = fp_ab_req;
        t_req_q = tp_ab_req;
        t_ack_q = tp_ab_ack;
        f_val_q = fp_a_value;
        t_val_q = tp_a_value;
    end

    // Synchronizer latency (R9), sampled in domain B
    logic fr_q = 0, tr_q = 0, f_pend = 0, t_pend = 0, f_ack_at = 0, t_ack_at = 0;
    always @(negedge clk_b) begin
        if (rst_a_n && rst_b_n) begin
            if (f_pend) begin
                pb_chk++;
                if (fp_ab_ack != f_ack_at) begin pb_fail++; $display("FAIL R9 4ph ack too early: got %0b expected %0b", fp_ab_ack, f_ack_at); end
                f_pend = 0;
            end
            if (t_pend) begin
                pb_chk++;
                if (tp_ab_ack != t_ack_at) begin pb_fail++; $display("FAIL R9 2ph ack too early: got %0b expected %0b", tp_ab_ack, t_ack_at); end
                t_pend = 0;
            end
            if (fp_ab_req != fr_q) begin f_pend = 1; f_ack_at = fp_ab_ack; end
            if (tp_ab_req != tr_q) begin t_pend = 1; t_ack_at = tp_ab_ack; end
        end
        fr_q = fp_ab_req;
        tr_q = tp_ab_req;
    end

    initial begin
        repeat (60000) @(posedge clk_b);
        wd = 1'b1;
    end

    task automatic check(input bit ok, input string what, input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, expv);
        end
    endtask

    // Walk the table against one instance: two = 0 selects four-phase
    task automatic walk(input bit two);
        for (int i = 0; i < 10; i++) begin
            logic al, bl;
            al = 0; bl = 0;
            while (!(al || bl) && !wd) begin
                @(negedge clk_a);
                al = two ? tp_a_loaded : fp_a_loaded;
                bl = two ? tp_b_loaded : fp_b_loaded;
            end
            check(bl == VEC[i][W], $sformatf("R2 order entry %0d (1=B side)", i), int'(bl), int'(VEC[i][W]));
            if (bl) check((two ? tp_b_value : fp_b_value) == VEC[i][W-1:0], "R3 table B value",
                          int'(two ? tp_b_value : fp_b_value), int'(VEC[i][W-1:0]));
            else    check((two ? tp_a_value : fp_a_value) == VEC[i][W-1:0], "R3 table A value",
                          int'(two ? tp_a_value : fp_a_value), int'(VEC[i][W-1:0]));
            while ((two ? (tp_a_loaded || tp_b_loaded) : (fp_a_loaded || fp_b_loaded)) && !wd)
                @(negedge clk_a);
        end
    endtask

    initial begin
        int tot_chk, tot_fail;
        repeat (3) @(negedge clk_b);
        // R1: reset state of both builds
        check({fp_a_value, fp_b_value, fp_a_loaded, fp_b_loaded, fp_ab_req, fp_ab_ack, fp_ba_req, fp_ba_ack} == '0,
              "R1 4ph reset outputs", int'(fp_a_value) + int'(fp_b_value), 0);
        check({tp_a_value, tp_b_value, tp_a_loaded, tp_b_loaded, tp_ab_req, tp_ab_ack, tp_ba_req, tp_ba_ack} == '0,
              "R1 2ph reset outputs", int'(tp_a_value) + int'(tp_b_value), 0);
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;

        fork
            walk(1'b0);
            walk(1'b1);
        join

        // Long run across the wrap point (R7)
        while (!wd && (m_ld[0] < 140 || m_ld[2] < 140)) @(negedge clk_b);
        check(m_wr[0] == 1'b1, "R7 4ph side A reached 0 after 255", int'(m_wr[0]), 1);
        check(m_wr[2] == 1'b1, "R7 2ph side A reached 0 after 255", int'(m_wr[2]), 1);
        check(m_ld[1] >= 140, "R3 4ph side B kept loading", m_ld[1], 140);
        check(m_ld[3] >= 140, "R3 2ph side B kept loading", m_ld[3], 140);
        check(pb_chk > 0, "R9 latency samples taken", pb_chk, 1);
        check(t_rq_n > 0, "R5 two-phase toggles seen", t_rq_n, 1);
        if (wd) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got expired expected finished");
        end

        tot_chk  = n_chk + pa_chk + pb_chk;
        tot_fail = n_fail + pa_fail + pb_fail;
        for (int k = 0; k < 4; k++) begin
            tot_chk  += m_chk[k];
            tot_fail += m_fail[k];
        end
        $display("[TB] %0d tests run, %0d failed", tot_chk, tot_fail);
        $finish;
    end
endmodule